// File: doc/BRIEF.md
# Constant On-Time PWM Sequencer

This block produces the two gate-timing commands for a synchronous buck stage: a high-side drive and a low-side drive. It keeps no switching period of its own. A new switching cycle begins only when the feedback comparator reports the output below reference, the minimum off-time since the last high-side pulse has run out, and the valley current comparator is quiet. The high-side pulse then lasts for a cycle count taken from an input word. That count is captured when the pulse starts. Both drives are held low for a fixed dead time at every hand-over between them.

A two-bit mode code picks the operating mode. It is assumed to be already sampled from a three-level pad. In forced continuous mode the low side conducts for the whole off phase. In diode-emulation mode the low side is released on the first zero-crossing report and stays released until the next off phase. In that mode the on-time never changes, so at light load only the off interval grows. Two override inputs, force-off and force-low-side-on, take over from the sequencer at once. After every override or shutdown, the sequencer restarts from idle with a fresh minimum off-time.

Top module: `cot_pwm_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, both drives are low.
- R2: Mode code 2'b00 and the unused code 2'b11 both mean shutdown. They drive both outputs low in the same cycle. Code 2'b01 selects diode emulation and 2'b10 selects forced continuous mode.
- R3: A pulse starts only when fb_low is high and the minimum off-time has elapsed. Exactly DT_CYC cycles with both drives low separate the fall of the low side from the rise of the high side.
- R4: The high side stays on for exactly ton_cycles clock cycles, and a value of 0 counts as 1. The count is captured at the start of the pulse, so a change during a pulse only takes effect from the next pulse.
- R5: After the high side falls, both drives stay low for exactly DT_CYC cycles before the low side turns on.
- R6: Between two high-side pulses the high side is low for at least TOFF_CYC cycles. When fb_low is held high the interval is exactly TOFF_CYC+DT_CYC cycles.
- R7: While valley_oc is high during the off phase, no new pulse starts.
- R8: In diode emulation, the low side is low from the cycle after zero_cross is sampled high. It stays low until the off phase of the next switching cycle, even if zero_cross drops.
- R9: In forced continuous mode zero_cross has no effect, and the low side stays on through the off phase.
- R10: force_off drives both outputs low in the same cycle and wins over force_ls_on. Once released, sequencing restarts from idle.
- R11: force_ls_on, with force_off low and the mode not shutdown, holds the low side on and the high side off in the same cycle for as long as it is high. On release both drives go low.
- R12: The two drives are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_code | input | 2 | Sampled mode: 00/11 shutdown, 01 diode emulation, 10 forced continuous |
| fb_low | input | 1 | Feedback below reference |
| valley_oc | input | 1 | Valley current above limit |
| zero_cross | input | 1 | Low-side current reached zero |
| ton_cycles | input | TON_W | High-side on-time in clock cycles |
| force_off | input | 1 | Override: both drives low |
| force_ls_on | input | 1 | Override: low side on, high side off |
| hs_drv | output | 1 | High-side gate command |
| ls_drv | output | 1 | Low-side gate command |

## Verification
The override inputs and the shutdown code act on the outputs with no register in the path, so the bench samples them one nanosecond after driving them. zero_cross goes through one register and is checked at the next falling clock edge. The dead times, on-times and off intervals are counted in falling-edge samples and compared with DT_CYC, ton_cycles and TOFF_CYC+DT_CYC. Each measurement starts at a defined edge of a drive output, so a check never depends on how long an earlier step took. A monitor sampling just before each rising edge records any overlap of the drives and the shortest high-side low interval over the whole run.

// File: rtl/cot_pkg.sv
`timescale 1ns/1ps
// Shared types for the constant on-time sequencer.
// Assumes the mode code is already synchronised by the pad logic.
package cot_pkg;
    typedef enum logic [1:0] {
        MODE_SHUT = 2'b00,
        MODE_DEM  = 2'b01,
        MODE_CCM  = 2'b10,
        MODE_BAD  = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DT_LS,
        ST_OFF,
        ST_DT_HS,
        ST_ON
    } seq_st_e;
endpackage

// File: rtl/cot_mode_decode.sv
`timescale 1ns/1ps
// Decodes the two-bit mode code into a run enable and a diode-emulation flag.
// Assumes mode_code is stable for the cycle (sampled upstream).
module cot_mode_decode
    import cot_pkg::*;
(
    input  logic [1:0] mode_code,
    output logic       run_en,
    output logic       dem_en
);
    // Map each code to its operating mode; unused code falls back to shutdown.
    always_comb begin
        case (mode_e'(mode_code))
            MODE_DEM: begin run_en = 1'b1; dem_en = 1'b1; end
            MODE_CCM: begin run_en = 1'b1; dem_en = 1'b0; end
            default:  begin run_en = 1'b0; dem_en = 1'b0; end
        endcase
    end
endmodule

// File: rtl/cot_oneshot.sv
`timescale 1ns/1ps
// Down-counting one-shot: load sets the count, done is high once it reaches zero.
// Assumes load_val = desired cycles minus one.
module cot_oneshot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    // Load or count down toward zero, then rest there.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - W'(1);
    end

    assign done = (cnt == '0);

    // Without a load an expired one-shot stays expired (supports R4, R6 timing).
    p_rest_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && done) |=> done);
endmodule

// File: rtl/cot_pwm_seq.sv
`timescale 1ns/1ps
// Constant on-time PWM sequencer for a synchronous buck stage.
// Starts a cycle on fb_low after the minimum off-time, times the high-side
// pulse from ton_cycles, inserts dead time at both hand-overs, applies the
// valley current block and diode-emulation release, and honours overrides.
// Assumes all comparator inputs are synchronous to clk.
module cot_pwm_seq
    import cot_pkg::*;
#(
    parameter int TON_W    = 12,
    parameter int DT_CYC   = 6,
    parameter int TOFF_CYC = 80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_code,
    input  logic             fb_low,
    input  logic             valley_oc,
    input  logic             zero_cross,
    input  logic [TON_W-1:0] ton_cycles,
    input  logic             force_off,
    input  logic             force_ls_on,
    output logic             hs_drv,
    output logic             ls_drv
);
    localparam int DT_W  = $clog2(DT_CYC + 1);
    localparam int OFF_W = $clog2(TOFF_CYC + 1);
    localparam logic [DT_W-1:0]  DT_LOAD  = DT_W'(DT_CYC - 1);
    localparam logic [OFF_W-1:0] OFF_LOAD = OFF_W'(TOFF_CYC - 1);

    seq_st_e          st, st_n;
    logic             run_en, dem_en, run;
    logic             dt_ld, off_ld, on_ld;
    logic             dt_done, off_done, on_done;
    logic             zc_seen;
    logic [TON_W-1:0] on_val;

    cot_mode_decode u_mode (
        .mode_code (mode_code),
        .run_en    (run_en),
        .dem_en    (dem_en)
    );

    assign run    = run_en && !force_off && !force_ls_on;
    assign on_val = (ton_cycles == '0) ? '0 : ton_cycles - TON_W'(1);

    cot_oneshot #(.W(DT_W)) u_dead (
        .clk (clk), .rst_n (rst_n), .load (dt_ld), .load_val (DT_LOAD), .done (dt_done)
    );
    cot_oneshot #(.W(OFF_W)) u_minoff (
        .clk (clk), .rst_n (rst_n), .load (off_ld), .load_val (OFF_LOAD), .done (off_done)
    );
    cot_oneshot #(.W(TON_W)) u_ontime (
        .clk (clk), .rst_n (rst_n), .load (on_ld), .load_val (on_val), .done (on_done)
    );

    // Next-state and one-shot loads; any override or shutdown returns to idle.
    always_comb begin
        st_n   = st;
        dt_ld  = 1'b0;
        off_ld = 1'b0;
        on_ld  = 1'b0;
        if (!run) begin
            st_n = ST_IDLE;
        end else begin
            case (st)
                ST_IDLE: begin
                    st_n = ST_DT_LS; dt_ld = 1'b1; off_ld = 1'b1;
                end
                ST_DT_LS: if (dt_done) st_n = ST_OFF;
                ST_OFF: if (off_done && fb_low && !valley_oc) begin
                    st_n = ST_DT_HS; dt_ld = 1'b1;
                end
                ST_DT_HS: if (dt_done) begin
                    st_n = ST_ON; on_ld = 1'b1;
                end
                ST_ON: if (on_done) begin
                    st_n = ST_DT_LS; dt_ld = 1'b1; off_ld = 1'b1;
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // Zero-cross latch: set in the off phase under diode emulation, cleared outside it.
    always_ff @(posedge clk) begin
        if (!rst_n)                               zc_seen <= 1'b0;
        else if (st != ST_OFF)                    zc_seen <= 1'b0;
        else if (dem_en && zero_cross)            zc_seen <= 1'b1;
    end

    assign hs_drv = run && (st == ST_ON);
    assign ls_drv = run_en && !force_off &&
                    (force_ls_on || ((st == ST_OFF) && !(dem_en && zc_seen)));

    // ---------------- assertions ----------------
    logic [OFF_W-1:0] hs_low_cnt;

    // Count high-side low cycles, saturating at the minimum off-time.
    always_ff @(posedge clk) begin
        if (!rst_n)                              hs_low_cnt <= '0;
        else if (hs_drv)                         hs_low_cnt <= '0;
        else if (hs_low_cnt != OFF_W'(TOFF_CYC)) hs_low_cnt <= hs_low_cnt + OFF_W'(1);
    end

    p_no_overlap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_drv && ls_drv));

    p_min_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_drv) |-> (hs_low_cnt == OFF_W'(TOFF_CYC)));

    p_dead_before_hs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_drv) |-> ($past(st) == ST_DT_HS));

    p_oc_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OFF && valley_oc) |=> (st != ST_DT_HS));

    p_force_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (force_off || force_ls_on) |=> (st == ST_IDLE));

    p_shut_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (st == ST_IDLE));

    p_zc_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OFF && $past(st == ST_OFF) && $past(dem_en && zero_cross)
         && dem_en && !force_ls_on) |-> !ls_drv);
endmodule

// File: tb/cot_pwm_seq_bench.sv
`timescale 1ns/1ps
module cot_pwm_seq_bench;
    localparam int TON_W = 12;
    localparam int DT    = 6;
    localparam int TOFF  = 80;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       mode_code = 2'b10;
    logic             fb_low = 1'b0, valley_oc = 1'b0, zero_cross = 1'b0;
    logic [TON_W-1:0] ton_cycles = 12'd10;
    logic             force_off = 1'b0, force_ls_on = 1'b0;
    logic             hs_drv, ls_drv;

    int  total = 0, bad = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    cot_pwm_seq #(.TON_W(TON_W), .DT_CYC(DT), .TOFF_CYC(TOFF)) u_cot_pwm_seq (
        .clk (clk), .rst_n (rst_n), .mode_code (mode_code), .fb_low (fb_low),
        .valley_oc (valley_oc), .zero_cross (zero_cross), .ton_cycles (ton_cycles),
        .force_off (force_off), .force_ls_on (force_ls_on),
        .hs_drv (hs_drv), .ls_drv (ls_drv)
    );

    // Vectors: {mode[1:0], valley_oc, ton[11:0], expected width[11:0]}; width 0 = no pulse.
    localparam logic [26:0] VEC [11] = '{
        {2'b10, 1'b0, 12'd20,  12'd20},
        {2'b01, 1'b0, 12'd20,  12'd20},
        {2'b10, 1'b0, 12'd1,   12'd1},
        {2'b10, 1'b0, 12'd0,   12'd1},
        {2'b01, 1'b0, 12'd100, 12'd100},
        {2'b10, 1'b1, 12'd35,  12'd0},
        {2'b01, 1'b1, 12'd35,  12'd0},
        {2'b00, 1'b0, 12'd20,  12'd0},
        {2'b11, 1'b0, 12'd20,  12'd0},
        {2'b10, 1'b0, 12'd7,   12'd7},
        {2'b01, 1'b0, 12'd13,  12'd13}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic wait_hs(input logic v, input int maxc, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < maxc; i++) begin
            if (hs_drv === v) begin ok = 1'b1; break; end
            tick();
        end
    endtask

    task automatic measure_high(output int w);
        w = 0;
        while (hs_drv === 1'b1 && w < 5000) begin w++; tick(); end
    endtask

    // Monitor just before each rising edge: overlap and shortest high-side low run.
    int   overlap = 0, min_gap = 1000000, low_run = 0;
    bit   seen_fall = 1'b0;
    logic prev_hs = 1'b0;
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (hs_drv && ls_drv) overlap++;
            if (hs_drv) begin
                if (!prev_hs && seen_fall && low_run < min_gap) min_gap = low_run;
                low_run = 0;
            end else begin
                if (prev_hs) seen_fall = 1'b1;
                low_run++;
            end
            prev_hs = hs_drv;
        end
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit ok;
        int w, d1, l, d2, c;

        // R1: reset state
        repeat (4) tick();
        chk(!hs_drv && !ls_drv, "R1 drives low in reset", {hs_drv, ls_drv}, 0);
        rst_n = 1'b1;
        #1;
        chk(!hs_drv && !ls_drv, "R1 drives low right after release", {hs_drv, ls_drv}, 0);
        repeat (12) tick();
        chk(ls_drv && !hs_drv, "R5 low side on after startup dead time", {hs_drv, ls_drv}, 1);

        // R3, R5, R6: one full cycle with fb_low held high
        fb_low = 1'b1;
        wait_hs(1'b1, 300, ok);
        chk(ok, "R3 pulse starts on fb_low", ok, 1);
        measure_high(w);
        chk(w == 10, "R4 width ton=10", w, 10);
        d1 = 0;
        while (!ls_drv && !hs_drv && d1 < 200) begin d1++; tick(); end
        chk(d1 == DT, "R5 dead time after high side", d1, DT);
        l = 0;
        while (ls_drv && l < 500) begin l++; tick(); end
        d2 = 0;
        while (!ls_drv && !hs_drv && d2 < 200) begin d2++; tick(); end
        chk(d2 == DT, "R3 dead time before high side", d2, DT);
        chk(hs_drv && (d1 + l + d2 == TOFF + DT), "R6 off interval", d1 + l + d2, TOFF + DT);

        // R4: on-time captured at pulse start
        measure_high(w);
        ton_cycles = 12'd100;
        wait_hs(1'b1, 300, ok);
        ton_cycles = 12'd5;
        measure_high(w);
        chk(w == 100, "R4 mid-pulse change ignored", w, 100);
        wait_hs(1'b1, 300, ok);
        measure_high(w);
        chk(w == 5, "R4 new value at next pulse", w, 5);

        // Vector table
        for (int k = 0; k < 11; k++) begin
            while (hs_drv) tick();
            mode_code  = VEC[k][26:25];
            valley_oc  = VEC[k][24];
            ton_cycles = VEC[k][23:12];
            fb_low     = 1'b1;
            wait_hs(1'b1, 400, ok);
            if (VEC[k][11:0] == 12'd0) begin
                if (VEC[k][24]) chk(!ok, "R7 valley limit blocks start", ok, 0);
                else            chk(!ok, "R2 shutdown code blocks pulses", ok, 0);
            end else begin
                chk(ok, "R3 pulse starts for vector", ok, 1);
                measure_high(w);
                chk(w == int'(VEC[k][11:0]), "R4 width for vector", w, int'(VEC[k][11:0]));
            end
        end
        valley_oc = 1'b0;

        // R8: diode-emulation release on zero crossing
        mode_code = 2'b01; ton_cycles = 12'd10;
        wait_hs(1'b1, 300, ok);
        fb_low = 1'b0;
        wait_hs(1'b0, 300, ok);
        c = 0;
        while (!ls_drv && c < 50) begin c++; tick(); end
        chk(ls_drv, "R5 low side on in off phase", ls_drv, 1);
        zero_cross = 1'b1;
        tick();
        chk(!ls_drv, "R8 low side off after zero cross", ls_drv, 0);
        zero_cross = 1'b0;
        repeat (10) tick();
        chk(!ls_drv, "R8 low side stays off", ls_drv, 0);
        fb_low = 1'b1;
        wait_hs(1'b1, 300, ok);
        chk(ok, "R8 next cycle starts", ok, 1);
        fb_low = 1'b0;
        wait_hs(1'b0, 300, ok);
        c = 0;
        while (!ls_drv && c < 50) begin c++; tick(); end
        chk(c == DT, "R8 low side returns next off phase", c, DT);

        // R9: forced continuous ignores zero crossing
        mode_code = 2'b10;
        zero_cross = 1'b1;
        repeat (10) tick();
        chk(ls_drv && !hs_drv, "R9 zero cross ignored", {hs_drv, ls_drv}, 1);
        zero_cross = 1'b0;

        // R10, R11: overrides
        force_off = 1'b1; force_ls_on = 1'b1;
        #1;
        chk(!hs_drv && !ls_drv, "R10 force_off wins over force_ls_on", {hs_drv, ls_drv}, 0);
        tick();
        chk(!hs_drv && !ls_drv, "R10 both low held", {hs_drv, ls_drv}, 0);
        force_off = 1'b0;
        #1;
        chk(ls_drv && !hs_drv, "R11 low side forced on", {hs_drv, ls_drv}, 1);
        fb_low = 1'b1;
        repeat (20) tick();
        chk(ls_drv && !hs_drv, "R11 override held against fb_low", {hs_drv, ls_drv}, 1);
        force_ls_on = 1'b0;
        #1;
        chk(!hs_drv && !ls_drv, "R11 release returns to idle", {hs_drv, ls_drv}, 0);
        wait_hs(1'b1, 300, ok);
        chk(ok, "R10 sequencing resumes", ok, 1);
        force_off = 1'b1;
        #1;
        chk(!hs_drv && !ls_drv, "R10 cuts a live pulse", {hs_drv, ls_drv}, 0);
        tick();
        force_off = 1'b0;
        wait_hs(1'b1, 300, ok);
        force_ls_on = 1'b1;
        #1;
        chk(ls_drv && !hs_drv, "R11 override during pulse", {hs_drv, ls_drv}, 1);
        tick();
        force_ls_on = 1'b0;

        // R2: shutdown mid-pulse
        ton_cycles = 12'd50;
        wait_hs(1'b1, 300, ok);
        mode_code = 2'b00;
        #1;
        chk(!hs_drv && !ls_drv, "R2 shutdown cuts pulse", {hs_drv, ls_drv}, 0);
        tick();
        mode_code = 2'b10;
        wait_hs(1'b1, 300, ok);
        chk(ok, "R2 resumes after shutdown", ok, 1);

        repeat (5) tick();
        chk(overlap == 0, "R12 drives never overlap", overlap, 0);
        chk(min_gap >= TOFF, "R6 shortest off interval", min_gap, TOFF);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule